// File: doc/BRIEF.md
# Graphics Special-Register Command Decoder

This block sits on the command input of a graphics memory and classifies each clock's command from the chip-select, row-strobe, column-strobe and write-enable pins. A separate graphics-select pin decides whether the command keeps its ordinary memory meaning or takes its graphics meaning. With graphics-select low, every command decodes as the ordinary one. With it high, three encodings change meaning. Row activate becomes activate with per-bit write masking. Write becomes block write. The all-strobes-low mode-set command becomes a special register load.

The special register load fills two 32-bit registers, one bit per data lane, from the data input bus. These are a per-lane write mask and a fill color. Address bit 5 selects the mask and address bit 6 selects the color, and both may be loaded by the same command. A load may be issued while a bank is open, but not while the data bus is carrying a transfer. A load attempted during a transfer is refused, raises a one-clock error pulse, and leaves both registers as they were. An ordinary mode-set issued while a bank is open is also flagged. The decoded command code, both register contents and the error flag are all registered and appear one clock after the command is sampled.

Top module: `gfx_cmd_decoder`

## Requirements
- R1: During and right after reset, `cmd_q` reads 1 (no-op), `mask_q` is all ones, `color_q` is zero and `err_q` is 0.
- R2: With graphics-select low and chip-select low, the strobes {ras_n,cas_n,we_n} decode one clock later on `cmd_q` as: 111→1 no-op, 011→2 activate, 101→4 read, 100→5 write, 010→7 precharge, 001→8 refresh, 000→9 mode-set, 110→11 burst stop.
- R3: With graphics-select high, 011 decodes as 3 (activate with per-bit mask), 100 as 6 (block write) and 000 as 10 (special register load).
- R4: Graphics-select does not change the codes for 111, 101, 010, 001 and 110. Chip-select high decodes as 0 (deselect) whatever the other pins are.
- R5: A special register load with `a5` high and `dq_busy` low copies `dq_in` into `mask_q`, visible one clock later.
- R6: A special register load with `a6` high and `dq_busy` low copies `dq_in` into `color_q`, visible one clock later.
- R7: With `a5` and `a6` both high, one special register load writes the same `dq_in` word into both registers on the same edge.
- R8: A special register load with neither `a5` nor `a6` high, or any other command with `a5`/`a6` high, leaves both registers unchanged and raises no error.
- R9: A special register load is accepted while `bank_active` is high, provided `dq_busy` is low.
- R10: A special register load with `dq_busy` high leaves both registers unchanged and sets `err_q` for exactly the following clock.
- R11: An ordinary mode-set with `bank_active` high sets `err_q` for one clock. A mode-set with no bank open raises no error. A mode-set never alters either register.
- R12: Special register loads on consecutive clocks each take effect, so that each clock shows the word written on the clock before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| dsf | input | 1 | Graphics-select, high selects graphics meaning |
| a5 | input | 1 | Address bit 5: selects the mask register on a load |
| a6 | input | 1 | Address bit 6: selects the color register on a load |
| dq_in | input | 32 | Data input bus, source of register loads |
| bank_active | input | 1 | High while any bank is open |
| dq_busy | input | 1 | High while the data bus carries a transfer |
| cmd_q | output | 4 | Registered decoded command code |
| mask_q | output | 32 | Per-lane write mask register |
| color_q | output | 32 | Fill color register |
| err_q | output | 1 | One-clock error pulse for a refused command |

## Verification
Two things can happen in the same cycle: the mask and color registers can be written together, and a load can be refused because the data bus is busy. The bench provokes both at once. It issues loads with both address bits high, first with the bus idle, where both registers must take the same word. It then issues the same load with the bus busy, where neither register may move and the error pulse must appear. Every vector is judged against a scoreboard model that keeps its own copies of the two registers, which also covers back-to-back loads and loads issued while a bank is open.

// File: rtl/gfx_cmd_pkg.sv
package gfx_cmd_pkg;

  typedef enum logic [3:0] {
    GC_DESEL      = 4'd0,
    GC_NOP        = 4'd1,
    GC_ACT        = 4'd2,
    GC_ACT_WPB    = 4'd3,
    GC_READ       = 4'd4,
    GC_WRITE      = 4'd5,
    GC_BLK_WRITE  = 4'd6,
    GC_PRECHARGE  = 4'd7,
    GC_REFRESH    = 4'd8,
    GC_MODE_SET   = 4'd9,
    GC_SPEC_SET   = 4'd10,
    GC_BURST_STOP = 4'd11
  } gcmd_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } pins_t;

  // Ordinary meaning of the strobe pattern, graphics-select ignored.
  function automatic gcmd_e plain_cmd(pins_t p);
    gcmd_e c;
    if (p.cs_n) begin
      c = GC_DESEL;
    end else begin
      unique case ({p.ras_n, p.cas_n, p.we_n})
        3'b111:  c = GC_NOP;
        3'b011:  c = GC_ACT;
        3'b101:  c = GC_READ;
        3'b100:  c = GC_WRITE;
        3'b010:  c = GC_PRECHARGE;
        3'b001:  c = GC_REFRESH;
        3'b000:  c = GC_MODE_SET;
        default: c = GC_BURST_STOP;
      endcase
    end
    return c;
  endfunction

  // Graphics meaning: only three ordinary commands have a variant.
  function automatic gcmd_e graphic_remap(gcmd_e c, logic sel);
    gcmd_e r;
    r = c;
    if (sel) begin
      case (c)
        GC_ACT:      r = GC_ACT_WPB;
        GC_WRITE:    r = GC_BLK_WRITE;
        GC_MODE_SET: r = GC_SPEC_SET;
        default:     r = c;
      endcase
    end
    return r;
  endfunction

  function automatic logic is_graphic(gcmd_e c);
    return (c == GC_ACT_WPB) || (c == GC_BLK_WRITE) || (c == GC_SPEC_SET);
  endfunction

endpackage

// File: rtl/gfx_pin_decode.sv
module gfx_pin_decode
  import gfx_cmd_pkg::*;
(
  input  logic  cs_n,
  input  logic  ras_n,
  input  logic  cas_n,
  input  logic  we_n,
  input  logic  dsf,
  output gcmd_e cmd_now,
  output logic  spec_load,
  output logic  mode_set
);

  pins_t pins;
  gcmd_e base_cmd;

  always_comb begin
    pins      = '{cs_n: cs_n, ras_n: ras_n, cas_n: cas_n, we_n: we_n};
    base_cmd  = plain_cmd(pins);
    cmd_now   = graphic_remap(base_cmd, dsf);
    spec_load = (cmd_now == GC_SPEC_SET);
    mode_set  = (cmd_now == GC_MODE_SET);
  end

endmodule

// File: rtl/gfx_load_ctrl.sv
module gfx_load_ctrl (
  input  logic spec_load,
  input  logic mode_set,
  input  logic sel_mask,
  input  logic sel_color,
  input  logic bank_active,
  input  logic dq_busy,
  output logic mask_we,
  output logic color_we,
  output logic reject_now
);

  logic spec_ok;

  always_comb begin
    // Open banks do not block a special load; only bus traffic does.
    spec_ok    = spec_load && !dq_busy;
    mask_we    = spec_ok && sel_mask;
    color_we   = spec_ok && sel_color;
    reject_now = (spec_load && dq_busy) || (mode_set && bank_active);
  end

endmodule

// File: rtl/gfx_spec_reg.sv
module gfx_spec_reg #(
  parameter int             W       = 32,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n)     q <= RST_VAL;
    else if (wr_en) q <= wr_data;
  end

endmodule

// File: rtl/gfx_cmd_decoder.sv
module gfx_cmd_decoder
  import gfx_cmd_pkg::*;
#(
  parameter int DQ_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_n,
  input  logic            ras_n,
  input  logic            cas_n,
  input  logic            we_n,
  input  logic            dsf,
  input  logic            a5,
  input  logic            a6,
  input  logic [DQ_W-1:0] dq_in,
  input  logic            bank_active,
  input  logic            dq_busy,
  output logic [3:0]      cmd_q,
  output logic [DQ_W-1:0] mask_q,
  output logic [DQ_W-1:0] color_q,
  output logic            err_q
);

  localparam int NREG = 2;
  localparam logic [DQ_W-1:0] MASK_RST  = '1;
  localparam logic [DQ_W-1:0] COLOR_RST = '0;

  gcmd_e cmd_now;
  logic  spec_load;
  logic  mode_set;
  logic  mask_we;
  logic  color_we;
  logic  reject_now;

  logic [NREG-1:0]            reg_we;
  logic [NREG-1:0][DQ_W-1:0]  reg_q;

  gfx_pin_decode u_dec (
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .dsf       (dsf),
    .cmd_now   (cmd_now),
    .spec_load (spec_load),
    .mode_set  (mode_set)
  );

  gfx_load_ctrl u_ctl (
    .spec_load   (spec_load),
    .mode_set    (mode_set),
    .sel_mask    (a5),
    .sel_color   (a6),
    .bank_active (bank_active),
    .dq_busy     (dq_busy),
    .mask_we     (mask_we),
    .color_we    (color_we),
    .reject_now  (reject_now)
  );

  assign reg_we = {color_we, mask_we};

  // Index 0 is the mask, index 1 the color.
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [DQ_W-1:0] RV = (g == 0) ? MASK_RST : COLOR_RST;
    gfx_spec_reg #(.W(DQ_W), .RST_VAL(RV)) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_we[g]),
      .wr_data (dq_in),
      .q       (reg_q[g])
    );
  end

  assign mask_q  = reg_q[0];
  assign color_q = reg_q[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= GC_NOP;
      err_q <= 1'b0;
    end else begin
      cmd_q <= cmd_now;
      err_q <= reject_now;
    end
  end

endmodule

// File: rtl/gfx_cmd_decoder_chk.sv
module gfx_cmd_decoder_chk
  import gfx_cmd_pkg::*;
#(
  parameter int DQ_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            dsf,
  input logic [DQ_W-1:0] dq_in,
  input logic            bank_active,
  input logic            dq_busy,
  input logic [3:0]      cmd_q,
  input logic [DQ_W-1:0] mask_q,
  input logic [DQ_W-1:0] color_q,
  input logic            err_q,
  input logic            mask_we,
  input logic            color_we,
  input logic            reject_now
);

  p_plain_when_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !dsf |=> (cmd_q != GC_ACT_WPB && cmd_q != GC_BLK_WRITE && cmd_q != GC_SPEC_SET));

  p_mask_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (mask_q == $past(dq_in)));

  p_color_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    color_we |=> (color_q == $past(dq_in)));

  p_both_equal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_we && color_we) |=> (mask_q == color_q));

  p_mask_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we |=> $stable(mask_q));

  p_color_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !color_we |=> $stable(color_q));

  p_busy_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dq_busy |-> (!mask_we && !color_we));

  p_reject_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reject_now |=> (err_q && $stable(mask_q) && $stable(color_q)));

  p_err_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> ($past(dq_busy) || $past(bank_active)));

endmodule

bind gfx_cmd_decoder gfx_cmd_decoder_chk #(.DQ_W(DQ_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .dsf         (dsf),
  .dq_in       (dq_in),
  .bank_active (bank_active),
  .dq_busy     (dq_busy),
  .cmd_q       (cmd_q),
  .mask_q      (mask_q),
  .color_q     (color_q),
  .err_q       (err_q),
  .mask_we     (mask_we),
  .color_we    (color_we),
  .reject_now  (reject_now)
);

// File: tb/sim_gfx_cmd_decoder.sv
module sim_gfx_cmd_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  typedef struct {
    logic [3:0]   cmd;
    logic [W-1:0] mask;
    logic [W-1:0] color;
    logic         err;
    string        tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic dsf = 1'b0, a5 = 1'b0, a6 = 1'b0;
  logic [W-1:0] dq_in = '0;
  logic bank_active = 1'b0, dq_busy = 1'b0;
  logic [3:0] cmd_q;
  logic [W-1:0] mask_q, color_q;
  logic err_q;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;
  exp_t sb[$];
  logic [W-1:0] mdl_mask = '1;
  logic [W-1:0] mdl_color = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gfx_cmd_decoder #(.DQ_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .dsf(dsf), .a5(a5), .a6(a6), .dq_in(dq_in),
    .bank_active(bank_active), .dq_busy(dq_busy), .cmd_q(cmd_q),
    .mask_q(mask_q), .color_q(color_q), .err_q(err_q)
  );

  // Pins given as {cs,ras,cas,we}; code table restated from R2/R3/R4.
  function automatic logic [3:0] ref_code(logic [3:0] p, logic g);
    if (p[3]) return 4'd0;
    case (p[2:0])
      3'b111:  return 4'd1;
      3'b011:  return g ? 4'd3 : 4'd2;
      3'b101:  return 4'd4;
      3'b100:  return g ? 4'd6 : 4'd5;
      3'b010:  return 4'd7;
      3'b001:  return 4'd8;
      3'b000:  return g ? 4'd10 : 4'd9;
      default: return 4'd11;
    endcase
  endfunction

  task automatic check(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] p, input logic g, input logic m5,
                       input logic c6, input logic [W-1:0] d, input logic ba,
                       input logic busy, input string tag);
    exp_t e;
    logic all_low;
    @(negedge clk);
    {cs_n, ras_n, cas_n, we_n} = p;
    dsf = g; a5 = m5; a6 = c6; dq_in = d; bank_active = ba; dq_busy = busy;
    all_low = (p == 4'b0000);
    if (all_low && g && !busy) begin
      if (m5) mdl_mask = d;
      if (c6) mdl_color = d;
    end
    e.cmd   = ref_code(p, g);
    e.mask  = mdl_mask;
    e.color = mdl_color;
    e.err   = all_low && (g ? busy : ba);
    e.tag   = tag;
    sb.push_back(e);
  endtask

  // Monitor: results of the edge just passed.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, "cmd",   {28'd0, cmd_q}, {28'd0, e.cmd});
        check(e.tag, "mask",  mask_q,  e.mask);
        check(e.tag, "color", color_q, e.color);
        check(e.tag, "err",   {31'd0, err_q}, {31'd0, e.err});
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1", "cmd",   {28'd0, cmd_q}, 32'd1);
    check("R1", "mask",  mask_q, '1);
    check("R1", "color", color_q, '0);
    check("R1", "err",   {31'd0, err_q}, 32'd0);
    rst_n = 1'b1;
    apply(4'b0111, 1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R1");

    // R2 / R4: every strobe pattern, graphics-select low
    for (int i = 0; i < 8; i++)
      apply({1'b0, 3'(i)}, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, "R2");
    // R3 / R4: every strobe pattern, graphics-select high, no register select
    for (int i = 0; i < 8; i++)
      apply({1'b0, 3'(i)}, 1'b1, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, "R3");
    // R4: deselect wins regardless of pins
    apply(4'b1000, 1'b1, 1'b1, 1'b1, 32'hFFFF0000, 1'b0, 1'b0, "R4");
    apply(4'b1011, 1'b0, 1'b0, 1'b0, 32'h0, 1'b1, 1'b0, "R4");

    apply(4'b0000, 1'b1, 1'b1, 1'b0, 32'hA5A5_0F0F, 1'b0, 1'b0, "R5");
    apply(4'b0000, 1'b1, 1'b0, 1'b1, 32'h1234_5678, 1'b0, 1'b0, "R6");
    apply(4'b0000, 1'b1, 1'b1, 1'b1, 32'hC3C3_3C3C, 1'b0, 1'b0, "R7");
    // R8: no select bits, and other commands with select bits
    apply(4'b0000, 1'b1, 1'b0, 1'b0, 32'hDEAD_BEEF, 1'b0, 1'b0, "R8");
    apply(4'b0100, 1'b1, 1'b1, 1'b1, 32'h0BAD_F00D, 1'b0, 1'b0, "R8");
    apply(4'b0011, 1'b1, 1'b1, 1'b1, 32'h0BAD_F00D, 1'b1, 1'b0, "R8");
    apply(4'b0000, 1'b0, 1'b1, 1'b1, 32'h0BAD_F00D, 1'b0, 1'b0, "R8");
    // R9: bank open, bus idle
    apply(4'b0000, 1'b1, 1'b1, 1'b0, 32'h0000_FFFF, 1'b1, 1'b0, "R9");
    apply(4'b0000, 1'b1, 1'b0, 1'b1, 32'hFFFF_0001, 1'b1, 1'b0, "R9");
    // R10: bus busy, both selected, then a quiet clock for the pulse end
    apply(4'b0000, 1'b1, 1'b1, 1'b1, 32'h5555_AAAA, 1'b1, 1'b1, "R10");
    apply(4'b0111, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b1, "R10");
    apply(4'b0000, 1'b1, 1'b1, 1'b0, 32'h7777_7777, 1'b0, 1'b1, "R10");
    apply(4'b0111, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, "R10");
    // R11: mode-set with and without a bank open
    apply(4'b0000, 1'b0, 1'b1, 1'b1, 32'h1111_1111, 1'b1, 1'b0, "R11");
    apply(4'b0000, 1'b0, 1'b1, 1'b1, 32'h2222_2222, 1'b0, 1'b0, "R11");
    apply(4'b0000, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b1, "R11");
    // R12: back-to-back loads
    for (int i = 0; i < 6; i++)
      apply(4'b0000, 1'b1, 1'(i % 2 == 0), 1'(i % 3 != 0),
            32'h0101_0101 * (i + 3), 1'(i > 2), 1'b0, "R12");
    apply(4'b0111, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, "R12");

    @(posedge clk); @(posedge clk); #3;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule